// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block sits behind an Ethernet receive MAC and moves incoming frames into memory buffers owned through a circular list of descriptors. Each descriptor is four words in a descriptor memory: a status word, a length word and a buffer pointer, with one spare word. While no frame is in progress the engine keeps reading the current descriptor's status and pointer. When a frame begins, it stores the bytes at consecutive addresses from the pointer, writes the byte count back, and then writes the status with the ownership flag cleared. After that it steps to the next descriptor.

Software owns a descriptor while its EMPTY flag is clear and gives it to hardware by setting the flag. The ring length comes from a WRAP flag that software puts on the last descriptor only. If a frame arrives and the current descriptor is still owned by software, the engine drops the frame and raises a busy event. It then stays halted until software writes an explicit resume command. A small register port sets the ring base, the receive enable, the busy event and the halt state.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, all four registers read 0 and no descriptor or buffer writes occur. The registers are: word 0, ring base; word 1, bit 0 receive enable; word 2, bit 0 busy event; word 3, bit 0 halted.
- R2: The bytes of an accepted frame are written in order to consecutive buffer addresses. The first byte goes to the descriptor's pointer word, which is word offset 2 in the descriptor.
- R3: Completion writes the length word (offset 1) first and the status word (offset 0) on the next cycle. The length is the number of bytes received, including the 4-byte frame check sequence. In the status word, EMPTY (bit 15) is cleared and WRAP (bit 13) is kept.
- R4: After a descriptor with WRAP set, the next frame uses the descriptor at the ring base. Otherwise it uses the descriptor 4 words further on.
- R5: If rx_err is high on any byte of a frame, status bit 1 is set. The frame is still stored and EMPTY is still cleared.
- R6: Bytes beyond MAX_LEN are not stored. The reported length is MAX_LEN and status bit 2 (truncated) is set.
- R7: A frame that starts while the current descriptor has EMPTY clear is not stored. Bit 0 of word 2 (busy) and bit 0 of word 3 (halted) then read 1.
- R8: While halted, frames are dropped even after the descriptor is given back. Writing 1 to bit 0 of word 2 clears busy but not halted. Writing 1 to bit 0 of word 3 clears halted, and the next frame goes to the same descriptor.
- R9: Writing word 0 loads a new ring base and resets the descriptor index to 0.
- R10: A frame that starts while the receive enable is 0 is dropped whole and sets no busy event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 1 | Error seen on this byte |
| desc_rd | output | 1 | Descriptor memory read request |
| desc_wr | output | 1 | Descriptor memory write request |
| desc_addr | output | AW | Descriptor memory word address |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32 | Descriptor read data, one cycle after desc_rd |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | AW | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |

## Verification
Frames of several sizes are sent: 1 byte, mid-sized, and longer than MAX_LEN. This separates correct byte counting from truncation. Error frames show that the error flag is recorded without losing the frame. A three-entry ring is run past its WRAP entry and then reloaded at a new base, which checks the index step, the return to the base and the index reset. Frames that meet a software-owned descriptor, frames sent while halted or disabled, and the separate busy-clear and resume writes tell apart the drop paths that must raise busy from those that must not.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ST_EMPTY   = 15;
   localparam int ST_WRAP    = 13;
   localparam int ST_TRUNC   = 2;
   localparam int ST_ERR     = 1;
   localparam int OFS_STAT   = 0;
   localparam int OFS_LEN    = 1;
   localparam int OFS_PTR    = 2;
   localparam int DESC_SHIFT = 2;

   typedef enum logic [2:0] {
      S_POLL_STAT, S_POLL_PTR, S_POLL_CAP, S_RECV, S_DROP, S_WB_LEN, S_WB_STAT
   } eng_state_t;
endpackage

// File: rtl/rxr_csr.sv
module rxr_csr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          busy_set,
   output logic [AW-1:0] ring_base,
   output logic          rx_en,
   output logic          halted,
   output logic          base_load
);
   logic busy_evt;

   assign base_load = reg_wr && (reg_addr == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_base <= '0;
         rx_en     <= 1'b0;
         busy_evt  <= 1'b0;
         halted    <= 1'b0;
      end else begin
         if (base_load) ring_base <= reg_wdata[AW-1:0];
         if (reg_wr && reg_addr == 2'd1) rx_en <= reg_wdata[0];
         if (busy_set) busy_evt <= 1'b1;
         else if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) busy_evt <= 1'b0;
         if (busy_set) halted <= 1'b1;
         else if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) halted <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         2'd0:    reg_rdata = 32'(ring_base);
         2'd1:    reg_rdata = {31'b0, rx_en};
         2'd2:    reg_rdata = {31'b0, busy_evt};
         default: reg_rdata = {31'b0, halted};
      endcase
   end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int AW    = 32,
   parameter int IDX_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_load,
   input  logic          advance,
   input  logic          adv_wrap,
   input  logic [AW-1:0] ring_base,
   output logic [AW-1:0] desc_base
);
   import rxr_pkg::*;
   localparam logic [IDX_W-1:0] IDX_LAST = '1;

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              idx <= '0;
      else if (base_load)      idx <= '0;
      else if (advance)        idx <= adv_wrap ? '0 : idx + 1'b1;
   end

   assign desc_base = ring_base + (AW'(idx) << DESC_SHIFT);

   assert_wrap_to_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
      advance && adv_wrap && !base_load |=> desc_base == ring_base);
   assert_step_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !adv_wrap && !base_load && idx != IDX_LAST |=>
      desc_base == $past(desc_base) + (AW'(1) << DESC_SHIFT));
   assert_base_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      base_load |=> desc_base == ring_base);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
   parameter int AW      = 32,
   parameter int MAX_LEN = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic          rx_last,
   input  logic          rx_err,
   input  logic          rx_en,
   input  logic          halted,
   input  logic          base_load,
   input  logic [AW-1:0] desc_base,
   input  logic [31:0]   desc_rdata,
   output logic          desc_rd,
   output logic          desc_wr,
   output logic [AW-1:0] desc_addr,
   output logic [31:0]   desc_wdata,
   output logic          buf_we,
   output logic [AW-1:0] buf_addr,
   output logic          busy_set,
   output logic          advance,
   output logic          adv_wrap
);
   import rxr_pkg::*;
   localparam int CNT_W = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEN);

   eng_state_t       state;
   logic [15:0]      cur_stat;
   logic [AW-1:0]    cur_ptr;
   logic             cache_ok, err_f, trunc_f;
   logic [CNT_W-1:0] count;
   logic             in_poll, start, owned, accept, room;
   logic [15:0]      wb_stat;
   logic             unused_hi;

   assign unused_hi = ^desc_rdata[31:16];
   assign in_poll = (state == S_POLL_STAT) || (state == S_POLL_PTR) || (state == S_POLL_CAP);
   assign start   = in_poll && rx_valid;
   assign owned   = rx_en && !halted && cache_ok;
   assign accept  = start && owned && cur_stat[ST_EMPTY];
   assign room    = count < CNT_MAX;

   always_comb begin
      wb_stat           = '0;
      wb_stat[ST_WRAP]  = cur_stat[ST_WRAP];
      wb_stat[ST_ERR]   = err_f;
      wb_stat[ST_TRUNC] = trunc_f;
   end

   assign busy_set = start && owned && !cur_stat[ST_EMPTY];
   assign buf_we   = (accept || (state == S_RECV && rx_valid)) && room;
   assign buf_addr = cur_ptr + AW'(count);
   assign desc_rd  = (state == S_POLL_STAT) || (state == S_POLL_PTR);
   assign desc_wr  = (state == S_WB_LEN) || (state == S_WB_STAT);
   assign advance  = (state == S_WB_STAT);
   assign adv_wrap = cur_stat[ST_WRAP];

   always_comb begin
      case (state)
         S_POLL_PTR: desc_addr = desc_base + AW'(OFS_PTR);
         S_WB_LEN:   desc_addr = desc_base + AW'(OFS_LEN);
         default:    desc_addr = desc_base + AW'(OFS_STAT);
      endcase
      desc_wdata = (state == S_WB_LEN) ? 32'(count) : {16'b0, wb_stat};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_POLL_STAT;
         cur_stat <= '0;
         cur_ptr  <= '0;
         cache_ok <= 1'b0;
         err_f    <= 1'b0;
         trunc_f  <= 1'b0;
         count    <= '0;
      end else begin
         case (state)
            S_POLL_STAT, S_POLL_PTR, S_POLL_CAP: begin
               if (base_load) begin
                  state    <= S_POLL_STAT;
                  cache_ok <= 1'b0;
               end else if (accept) begin
                  count   <= CNT_W'(1);
                  err_f   <= rx_err;
                  trunc_f <= 1'b0;
                  state   <= rx_last ? S_WB_LEN : S_RECV;
               end else if (start) begin
                  state <= rx_last ? S_POLL_STAT : S_DROP;
               end else if (state == S_POLL_STAT) begin
                  state <= S_POLL_PTR;
               end else if (state == S_POLL_PTR) begin
                  cur_stat <= desc_rdata[15:0];
                  state    <= S_POLL_CAP;
               end else begin
                  cur_ptr  <= desc_rdata[AW-1:0];
                  cache_ok <= 1'b1;
                  state    <= S_POLL_STAT;
               end
            end
            S_RECV: if (rx_valid) begin
               if (room) count <= count + 1'b1;
               else      trunc_f <= 1'b1;
               err_f <= err_f | rx_err;
               if (rx_last) state <= S_WB_LEN;
            end
            S_DROP: if (rx_valid && rx_last) state <= S_POLL_STAT;
            S_WB_LEN: state <= S_WB_STAT;
            default: begin
               count    <= '0;
               cache_ok <= 1'b0;
               state    <= S_POLL_STAT;
            end
         endcase
      end
   end

   assert_buf_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we && $past(buf_we) |-> buf_addr == $past(buf_addr) + AW'(1));
   assert_disabled_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start && !rx_en |-> !buf_we && !busy_set);
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
   parameter int AW      = 32,
   parameter int IDX_W   = 8,
   parameter int MAX_LEN = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic          rx_err,
   output logic          desc_rd,
   output logic          desc_wr,
   output logic [AW-1:0] desc_addr,
   output logic [31:0]   desc_wdata,
   input  logic [31:0]   desc_rdata,
   output logic          buf_we,
   output logic [AW-1:0] buf_addr,
   output logic [7:0]    buf_data
);
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("rx_desc_ring: AW must lie in 8..32");
   end
   if (MAX_LEN < 1 || MAX_LEN > 65535) begin : g_bad_len
      $error("rx_desc_ring: MAX_LEN must lie in 1..65535");
   end
   if (IDX_W < 1 || IDX_W + 2 > AW) begin : g_bad_idx
      $error("rx_desc_ring: IDX_W out of range for AW");
   end

   logic [AW-1:0] ring_base, desc_base;
   logic          rx_en, halted, base_load, busy_set, advance, adv_wrap;

   assign buf_data = rx_data;

   rxr_csr #(.AW(AW)) u_csr (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_set(busy_set),
      .ring_base(ring_base), .rx_en(rx_en), .halted(halted), .base_load(base_load));

   rxr_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .base_load(base_load), .advance(advance),
      .adv_wrap(adv_wrap), .ring_base(ring_base), .desc_base(desc_base));

   rxr_engine #(.AW(AW), .MAX_LEN(MAX_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
      .rx_err(rx_err), .rx_en(rx_en), .halted(halted), .base_load(base_load),
      .desc_base(desc_base), .desc_rdata(desc_rdata), .desc_rd(desc_rd),
      .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .busy_set(busy_set),
      .advance(advance), .adv_wrap(adv_wrap));

   assert_busy_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_set |=> halted);
   assert_no_store_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !halted);
   assert_len_before_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_wr && desc_addr == desc_base |->
      $past(desc_wr) && $past(desc_addr) == desc_base + AW'(1));
   assert_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_rd && desc_wr));
endmodule

// File: tb/rx_desc_ring_tb.sv
`timescale 1ns/1ps
module rx_desc_ring_tb;
   localparam int MAXL = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        desc_rd, desc_wr, buf_we;
   logic [31:0] desc_addr, desc_wdata, buf_addr;
   logic [31:0] desc_rdata = '0;
   logic [7:0]  buf_data;

   logic [31:0] dmem [0:255];
   logic [39:0] bq[$];
   logic [63:0] dq[$];
   string       btag[$], dtag[$];
   int          nchecks = 0, nerrors = 0;
   int          base = 0;
   int          seed = 3;
   bit          done = 0;

   always #2.5 clk = ~clk;

   rx_desc_ring #(.AW(32), .IDX_W(8), .MAX_LEN(MAXL)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err), .desc_rd(desc_rd),
      .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
      .desc_rdata(desc_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_data(buf_data));

   always @(posedge clk) begin
      if (desc_wr) dmem[desc_addr[7:0]] <= desc_wdata;
      if (desc_rd) desc_rdata <= dmem[desc_addr[7:0]];
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchecks++;
      if (!ok) begin
         nerrors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected writes as the design produces them
   always @(negedge clk) begin
      if (rst_n && buf_we) begin
         if (bq.size() == 0) chk(0, "R2", "unexpected buffer write", {buf_addr, buf_data}, 0);
         else begin
            logic [39:0] e;
            string t;
            e = bq.pop_front(); t = btag.pop_front();
            chk({buf_addr, buf_data} == e, t, "buffer write", {buf_addr, buf_data}, e);
         end
      end
      if (rst_n && desc_wr) begin
         if (dq.size() == 0) chk(0, "R3", "unexpected descriptor write", {desc_addr, desc_wdata}, 0);
         else begin
            logic [63:0] e;
            string t;
            e = dq.pop_front(); t = dtag.pop_front();
            chk({desc_addr, desc_wdata} == e, t, "descriptor write", {desc_addr, desc_wdata}, e);
         end
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic reg_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      chk(reg_rdata == exp, tag, "register read", reg_rdata, exp);
   endtask

   task automatic arm(input int b, input int i, input bit wrap, input logic [31:0] ptr);
      @(posedge clk); #1;
      dmem[b + 4*i]     = 32'h8000 | (wrap ? 32'h2000 : 32'h0);
      dmem[b + 4*i + 1] = 32'h0;
      dmem[b + 4*i + 2] = ptr;
   endtask

   task automatic send_frame(input int n, input bit err, input bit acc, input int idx,
                             input bit wrap, input logic [31:0] ptr, input string tag);
      int stored;
      logic [31:0] st;
      stored = (n > MAXL) ? MAXL : n;
      if (acc) begin
         for (int i = 0; i < stored; i++) begin
            bq.push_back({ptr + 32'(i), 8'(seed + i)});
            btag.push_back(tag);
         end
         st = 32'h0;
         st[13] = wrap; st[1] = err; st[2] = (n > MAXL);
         dq.push_back({32'(base + 4*idx + 1), 32'(stored)}); dtag.push_back(tag);
         dq.push_back({32'(base + 4*idx), st});              dtag.push_back(tag);
      end
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         rx_valid = 1'b1; rx_data = 8'(seed + i);
         rx_last = (i == n - 1);
         rx_err = err && (i == ((n > 1) ? 1 : 0));
      end
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
      repeat (12) @(posedge clk);
      chk(bq.size() == 0 && dq.size() == 0, tag, "outstanding expected writes",
          64'(bq.size() + dq.size()), 0);
      seed += 17;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) dmem[i] = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 4; a++) reg_check(2'(a), 0, "R1");

      base = 32'h10;
      arm(base, 0, 0, 32'h1000);
      arm(base, 1, 0, 32'h2000);
      arm(base, 2, 1, 32'h3000);
      reg_write(2'd0, 32'h10);
      reg_write(2'd1, 32'h1);
      reg_check(2'd0, 32'h10, "R9");
      repeat (10) @(posedge clk);

      send_frame(20, 0, 1, 0, 0, 32'h1000, "R2");
      send_frame(9,  1, 1, 1, 0, 32'h2000, "R5");
      send_frame(70, 0, 1, 2, 1, 32'h3000, "R6");
      arm(base, 0, 0, 32'h1000);
      repeat (8) @(posedge clk);
      send_frame(5, 0, 1, 0, 0, 32'h1000, "R4");

      // R7: descriptor 1 still owned by software
      send_frame(10, 0, 0, 1, 0, 32'h2000, "R7");
      reg_check(2'd2, 32'h1, "R7");
      reg_check(2'd3, 32'h1, "R7");

      // R8: halted drops even after re-arm; resume sequence
      arm(base, 1, 0, 32'h2000);
      repeat (8) @(posedge clk);
      send_frame(6, 0, 0, 1, 0, 32'h2000, "R8");
      reg_write(2'd2, 32'h1);
      reg_check(2'd2, 32'h0, "R8");
      reg_check(2'd3, 32'h1, "R8");
      reg_write(2'd3, 32'h1);
      reg_check(2'd3, 32'h0, "R8");
      repeat (8) @(posedge clk);
      send_frame(12, 0, 1, 1, 0, 32'h2000, "R8");

      // R10: disabled; descriptor 2 is software-owned so busy would otherwise set
      reg_write(2'd1, 32'h0);
      send_frame(8, 0, 0, 2, 1, 32'h3000, "R10");
      reg_check(2'd2, 32'h0, "R10");
      reg_check(2'd3, 32'h0, "R10");
      reg_write(2'd1, 32'h1);

      // R9: new ring base resets the index
      arm(32'h40, 0, 0, 32'h5000);
      arm(32'h40, 1, 1, 32'h6000);
      reg_write(2'd0, 32'h40);
      base = 32'h40;
      repeat (10) @(posedge clk);
      send_frame(1,  0, 1, 0, 0, 32'h5000, "R9");
      send_frame(30, 1, 1, 1, 1, 32'h6000, "R3");
      arm(base, 0, 0, 32'h5000);
      repeat (8) @(posedge clk);
      send_frame(3, 0, 1, 0, 0, 32'h5000, "R4");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         nchecks++; nerrors++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
         $finish;
      end
   end
endmodule